// File: doc/BRIEF.md
# Network Board Control and Parity Capture Registers

This block holds the host-visible control word of a buffered network interface board, together with the registers that record a memory parity failure. The host reaches it over a 16-bit register bus. Every access is a full 16-bit word, and the word is picked by a two-bit address. Writes to the control word drive the network controller's hard reset, its channel-attention strobe and its release from loopback. They also set the secondary memory bus enable and the two interrupt enables.

The block also latches two kinds of event. The first is an interrupt request from the network controller. The second is a parity failure reported by the board memory's parity checker. On the first parity failure the block stores the failing byte lane, the failing source and the full 20-bit address. It keeps that record until the host writes the acknowledge bit, and any failure that arrives in the meantime is dropped. One interrupt line combines both latched events, and each event has its own enable.

Top module: `netctl_regs`

## Requirements
- R1: After synchronous reset, all control outputs are low, both event flags are clear, and the status word reads back as only the strap inputs: bit 4 is the large-RAM strap and bits 3:0 are the high RAM base strap.
- R2: A write to address 0 (status) loads bit 15 (board reset), bit 14 (on-air), bit 13 (attention), bit 12 (interrupt enable), bit 11 (parity interrupt enable) and bit 5 (secondary bus enable), and these bits read back unchanged. Bits 4:0 always show the straps, and writes do not change them.
- R3: A status write that changes the attention bit from 0 to 1, with bit 15 of the written word clear, produces exactly one cycle of `ctl_attn`, in the cycle after the write. Rewriting an attention bit that is already 1 produces no pulse.
- R4: While status bit 15 is set, `ctl_reset` is high and `ctl_attn`, `ctl_onair`, `sec_bus_en` and `irq_out` are all low.
- R5: A cycle with `ctl_irq` high sets the controller interrupt flag, which is status bit 8. A status write with bit 8 = 1 clears the flag. A status write with bit 8 = 0 leaves it unchanged.
- R6: `irq_out` is high exactly when the reset bit is clear and either (interrupt flag and interrupt enable) or (parity flag and parity interrupt enable) holds.
- R7: When no failure is held, a cycle with `par_err` high does three things. It sets the parity flag (status bit 9). It records `par_src` in parity-control bit 7, `par_side` in bit 6, and `par_addr[19:16]` in bits 3:0 of the parity-control register (address 1). It records `par_addr[15:0]` in the parity-address register (address 2).
- R8: While the parity flag is set, further `par_err` cycles change neither the flag nor any recorded field.
- R9: A write to address 1 with bit 8 = 1 clears the parity flag and re-arms capture. A write to address 1 with bit 8 = 0 has no effect. Bit 8 always reads as 0.
- R10: Address 3 reads as zero. A cycle with `bus_wr` high but `bus_sel` low changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Word select: 0 status, 1 parity control, 2 parity address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected word |
| strap_hibase | input | 4 | Board strap: high bits of RAM base address |
| strap_bigram | input | 1 | Board strap: large RAM fitted |
| ctl_irq | input | 1 | Interrupt request from network controller |
| par_err | input | 1 | Parity failure strobe from memory checker |
| par_src | input | 1 | Source of the failing access |
| par_side | input | 1 | Byte lane that failed |
| par_addr | input | 20 | Address of the failing access |
| ctl_reset | output | 1 | Hard reset to the controller |
| ctl_attn | output | 1 | One-cycle channel-attention pulse |
| ctl_onair | output | 1 | Release interface from loopback |
| sec_bus_en | output | 1 | Secondary memory bus enable |
| irq_out | output | 1 | Combined interrupt to host |

## Verification
Directed sequences cover the following cases:
- an attention rising edge, compared against a rewrite of an attention bit that is already set, which shows edge detection apart from level following;
- an attention rise written together with the reset bit;
- a second parity failure that arrives before acknowledge, which shows first-capture apart from last-capture;
- an acknowledge write with bit 8 clear, which shows decode of the acknowledge bit apart from plain address decode.

A seeded random phase then mixes random status words, controller requests, parity failures with random address, lane and source, and acknowledges. After every operation it compares readback and all control outputs against a reference model kept in the bench. This exercises every pairing of the two flags with the two enables, which a fault in the interrupt combining must break.

// File: rtl/netctl_pkg.sv
package netctl_pkg;

    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int PA_HI_W   = 4;
    localparam int PA_LO_W   = 16;
    localparam int PA_W      = PA_HI_W + PA_LO_W;
    localparam int STRAP_W   = 4;

    // status word bit positions
    localparam int SB_RESET  = 15;
    localparam int SB_ONAIR  = 14;
    localparam int SB_ATTN   = 13;
    localparam int SB_IEN    = 12;
    localparam int SB_PIEN   = 11;
    localparam int SB_PFLAG  = 9;
    localparam int SB_IFLAG  = 8;
    localparam int SB_SECBUS = 5;
    localparam int SB_BIGRAM = 4;

    // parity control word bit positions
    localparam int PB_ACK    = 8;
    localparam int PB_SRC    = 7;
    localparam int PB_SIDE   = 6;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_PCTRL  = 2'd1,
        REG_PADDR  = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic brd_reset;
        logic on_air;
        logic attn;
        logic irq_en;
        logic perr_irq_en;
        logic sec_bus;
    } ctrl_t;

    typedef struct packed {
        logic               src;
        logic               side;
        logic [PA_HI_W-1:0] hi;
        logic [PA_LO_W-1:0] lo;
    } perr_rec_t;

    localparam int REC_W = $bits(perr_rec_t);

    function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.brd_reset   = w[SB_RESET];
        c.on_air      = w[SB_ONAIR];
        c.attn        = w[SB_ATTN];
        c.irq_en      = w[SB_IEN];
        c.perr_irq_en = w[SB_PIEN];
        c.sec_bus     = w[SB_SECBUS];
        return c;
    endfunction

endpackage

// File: rtl/netctl_ctrl.sv
module netctl_ctrl
    import netctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              attn_pulse
);
    ctrl_t nxt;
    assign nxt = ctrl_from_word(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            attn_pulse <= 1'b0;
        end else begin
            attn_pulse <= wr_en && nxt.attn && !ctrl_q.attn && !nxt.brd_reset;
            if (wr_en) begin
                ctrl_q <= nxt;
            end
        end
    end
endmodule

// File: rtl/netctl_evflag.sv
module netctl_evflag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag_q
);
    // a new event in the same cycle as a clear wins, so no request is lost
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_ev) begin
            flag_q <= 1'b1;
        end else if (clr_ev) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/netctl_perr.sv
module netctl_perr
    import netctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      err_ev,
    input  perr_rec_t rec_in,
    input  logic      ack,
    output logic      held_q,
    output perr_rec_t rec_q
);
    logic take;
    assign take = err_ev && !held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            rec_q  <= '0;
        end else begin
            if (ack) begin
                held_q <= 1'b0;
            end else if (take) begin
                held_q <= 1'b1;
            end
            if (take) begin
                rec_q <= rec_in;
            end
        end
    end
endmodule

// File: rtl/netctl_regs.sv
module netctl_regs
    import netctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [STRAP_W-1:0] strap_hibase,
    input  logic               strap_bigram,
    input  logic               ctl_irq,
    input  logic               par_err,
    input  logic               par_src,
    input  logic               par_side,
    input  logic [PA_W-1:0]    par_addr,
    output logic               ctl_reset,
    output logic               ctl_attn,
    output logic               ctl_onair,
    output logic               sec_bus_en,
    output logic               irq_out
);
    reg_sel_e  sel;
    logic      wr_stat, wr_pctl, ack_wr, iclr;
    ctrl_t     ctrl_q;
    logic      attn_pulse, iflag, pflag;
    perr_rec_t rec_in, rec_q;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_stat = bus_sel && bus_wr && (sel == REG_STATUS);
    assign wr_pctl = bus_sel && bus_wr && (sel == REG_PCTRL);
    assign ack_wr  = wr_pctl && bus_wdata[PB_ACK];
    assign iclr    = wr_stat && bus_wdata[SB_IFLAG];

    assign rec_in.src  = par_src;
    assign rec_in.side = par_side;
    assign rec_in.hi   = par_addr[PA_W-1:PA_LO_W];
    assign rec_in.lo   = par_addr[PA_LO_W-1:0];

    netctl_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_stat),
        .wdata      (bus_wdata),
        .ctrl_q     (ctrl_q),
        .attn_pulse (attn_pulse)
    );

    netctl_evflag u_iflag (
        .clk    (clk),
        .rst    (rst),
        .set_ev (ctl_irq),
        .clr_ev (iclr),
        .flag_q (iflag)
    );

    netctl_perr u_perr (
        .clk    (clk),
        .rst    (rst),
        .err_ev (par_err),
        .rec_in (rec_in),
        .ack    (ack_wr),
        .held_q (pflag),
        .rec_q  (rec_q)
    );

    // control outputs, all quiet while the board reset bit is held
    logic live;
    assign live       = !ctrl_q.brd_reset;
    assign ctl_reset  = ctrl_q.brd_reset;
    assign ctl_attn   = attn_pulse && live;
    assign ctl_onair  = ctrl_q.on_air && live;
    assign sec_bus_en = ctrl_q.sec_bus && live;
    assign irq_out    = live && ((iflag && ctrl_q.irq_en) ||
                                 (pflag && ctrl_q.perr_irq_en));

    // read words
    logic [WORD_W-1:0] stat_word, pctl_word, padr_word;

    always_comb begin
        stat_word            = '0;
        stat_word[SB_RESET]  = ctrl_q.brd_reset;
        stat_word[SB_ONAIR]  = ctrl_q.on_air;
        stat_word[SB_ATTN]   = ctrl_q.attn;
        stat_word[SB_IEN]    = ctrl_q.irq_en;
        stat_word[SB_PIEN]   = ctrl_q.perr_irq_en;
        stat_word[SB_PFLAG]  = pflag;
        stat_word[SB_IFLAG]  = iflag;
        stat_word[SB_SECBUS] = ctrl_q.sec_bus;
        stat_word[SB_BIGRAM] = strap_bigram;
        stat_word[STRAP_W-1:0] = strap_hibase;
    end

    always_comb begin
        pctl_word               = '0;
        pctl_word[PB_SRC]       = rec_q.src;
        pctl_word[PB_SIDE]      = rec_q.side;
        pctl_word[PA_HI_W-1:0]  = rec_q.hi;
    end

    assign padr_word = rec_q.lo;

    always_comb begin
        unique case (sel)
            REG_STATUS: bus_rdata = stat_word;
            REG_PCTRL:  bus_rdata = pctl_word;
            REG_PADDR:  bus_rdata = padr_word;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/netctl_regs_chk.sv
module netctl_regs_chk
    import netctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ctl_reset,
    input logic             ctl_attn,
    input logic             ctl_onair,
    input logic             sec_bus_en,
    input logic             irq_out,
    input logic             iflag,
    input logic             pflag,
    input logic             ack_wr,
    input logic             par_err,
    input logic [REC_W-1:0] rec_q
);
    AST_ATTN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ctl_attn |=> !ctl_attn);                                           // R3
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        ctl_reset |-> !ctl_attn && !ctl_onair && !sec_bus_en && !irq_out); // R4
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (iflag || pflag));                                     // R6
    AST_CAPTURE_ARMS: assert property (@(posedge clk) disable iff (rst)
        (par_err && !pflag && !ack_wr) |=> pflag);                         // R7
    AST_RECORD_HELD: assert property (@(posedge clk) disable iff (rst)
        (pflag && !ack_wr) |=> pflag && $stable(rec_q));                   // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ack_wr |=> !pflag);                                                // R9
endmodule

bind netctl_regs netctl_regs_chk u_netctl_regs_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_reset  (ctl_reset),
    .ctl_attn   (ctl_attn),
    .ctl_onair  (ctl_onair),
    .sec_bus_en (sec_bus_en),
    .irq_out    (irq_out),
    .iflag      (iflag),
    .pflag      (pflag),
    .ack_wr     (ack_wr),
    .par_err    (par_err),
    .rec_q      (rec_q)
);

// File: tb/test_netctl_regs.sv
module test_netctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  strap_hibase = 4'hA;
    logic        strap_bigram = 1'b1;
    logic        ctl_irq = 1'b0, par_err = 1'b0, par_src = 1'b0, par_side = 1'b0;
    logic [19:0] par_addr = '0;
    logic        ctl_reset, ctl_attn, ctl_onair, sec_bus_en, irq_out;

    always #4 clk = ~clk;

    netctl_regs i_netctl_regs (.*);

    int checks = 0, fails = 0;

    // reference model
    logic m_rst = 0, m_onair = 0, m_attn = 0, m_ien = 0, m_pien = 0, m_sec = 0;
    logic m_if = 0, m_pf = 0, m_src = 0, m_side = 0;
    logic [19:0] m_pa = '0;
    logic m_pulse = 0;

    function automatic logic [15:0] exp_stat();
        return {m_rst, m_onair, m_attn, m_ien, m_pien, 1'b0, m_pf, m_if,
                2'b00, m_sec, strap_bigram, strap_hibase};
    endfunction
    function automatic logic [15:0] exp_pctl();
        return {8'h00, m_src, m_side, 2'b00, m_pa[19:16]};
    endfunction
    function automatic logic exp_irq();
        return !m_rst && ((m_if && m_ien) || (m_pf && m_pien));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // status write through the model
    task automatic wstat(input logic [15:0] d);
        m_pulse = d[13] && !m_attn && !d[15];
        m_rst = d[15]; m_onair = d[14]; m_attn = d[13]; m_ien = d[12];
        m_pien = d[11]; m_sec = d[5];
        if (d[8]) m_if = 0;
        wr(2'd0, d);
    endtask

    task automatic pctl_wr(input logic [15:0] d);
        if (d[8]) m_pf = 0;
        wr(2'd1, d);
    endtask

    task automatic ctl_ev();
        @(negedge clk); ctl_irq = 1;
        @(negedge clk); ctl_irq = 0;
        m_if = 1; m_pulse = 0;
    endtask

    task automatic perr_ev(input logic s, input logic e, input logic [19:0] a);
        @(negedge clk); par_err = 1; par_src = s; par_side = e; par_addr = a;
        @(negedge clk); par_err = 0;
        if (!m_pf) begin m_pf = 1; m_src = s; m_side = e; m_pa = a; end
        m_pulse = 0;
    endtask

    // compare everything visible against the model (called at a negedge)
    task automatic check_all(input string req);
        logic [15:0] v;
        rd(2'd0, v); chk({req, " status"}, v, exp_stat());
        rd(2'd1, v); chk({req, " pctl"}, v, exp_pctl());
        rd(2'd2, v); chk({req, " paddr"}, v, m_pa[15:0]);
        chk({req, " outs"}, {ctl_reset, ctl_attn, ctl_onair, sec_bus_en, irq_out},
            {m_rst, m_pulse && !m_rst, m_onair && !m_rst, m_sec && !m_rst, exp_irq()});
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_all("R1 reset state");

        // R2 field positions and strap bits ignore writes
        wstat(16'h581F); m_pulse = 0;
        check_all("R2 fields");
        // R3 attention rising edge
        wstat(16'h7820);
        check_all("R3 attn pulse");
        @(negedge clk); m_pulse = 0;
        check_all("R3 pulse ends");
        wstat(16'h7820);
        check_all("R3 no pulse on rewrite");
        wstat(16'h5820); m_pulse = 0;
        // R4 reset bit with attention rise
        wstat(16'hF820);
        check_all("R4 reset quiet");
        wstat(16'h5820); m_pulse = 0;
        // R5 interrupt flag and R6 combining
        ctl_ev();
        check_all("R5 iflag set R6 irq");
        wstat(16'h4820); m_pulse = 0;
        check_all("R5 W0 keeps flag R6 irq off");
        wstat(16'h5920); m_pulse = 0;
        check_all("R5 W1C clears flag");
        // R7 capture, R8 hold
        perr_ev(1'b1, 1'b0, 20'hB1234);
        check_all("R7 capture R6 parity irq");
        perr_ev(1'b0, 1'b1, 20'h5ABCD);
        check_all("R8 second error ignored");
        // R9 acknowledge
        pctl_wr(16'h00FF);
        check_all("R9 ack bit clear no effect");
        pctl_wr(16'h0100);
        check_all("R9 ack clears");
        perr_ev(1'b0, 1'b1, 20'h3C0DE);
        check_all("R9 rearmed capture");
        // R10 unused address and unselected write
        rd(2'd3, v); chk("R10 addr3 reads zero", v, 16'h0000);
        @(negedge clk); bus_sel = 0; bus_wr = 1; bus_addr = 2'd0; bus_wdata = 16'h8100;
        @(negedge clk); bus_wr = 0;
        check_all("R10 unselected write ignored");

        // seeded random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0, 1: begin
                    logic [15:0] d;
                    d = 16'($urandom);
                    if ($urandom_range(0, 3) != 0) d[15] = 0;
                    wstat(d);
                end
                2: ctl_ev();
                3: perr_ev(1'($urandom), 1'($urandom), 20'($urandom));
                default: begin
                    logic [15:0] d;
                    d = 16'($urandom);
                    pctl_wr(d);
                    m_pulse = 0;
                end
            endcase
            check_all("R6 random");
            m_pulse = 0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule